// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks reservations for load-exclusive and store-exclusive operations from a small group of processors that share one memory. Each processor has its own request port. A request carries an operation code, a byte address, write data and a flag that marks the location as shared. One request is accepted per cycle. When a store-exclusive arrives, the monitor decides whether the write may happen and returns a pass/fail status.

There are two tracking mechanisms, and they are kept apart:

- **Non-shared locations** use a single pending flag per processor. That flag does not record an address.
- **Shared locations** use one reserved word address per processor. A later exclusive load moves the reservation to the new address. Any successful write to a shared word cancels the reservations that other processors hold on that word.

A small word-addressed memory sits behind the monitor so that the effect of each write can be observed. Each processor can cancel its own reservation state through a dedicated clear input.

Top module: `excl_monitor`

## Requirements
- R1: When several request valids are high in the same cycle, only the lowest-numbered processor is accepted. `grant_o` is one-hot or zero and marks the processor accepted in that cycle.
- R2: Operation codes are 2'b00 load, 2'b01 store, 2'b10 load-exclusive and 2'b11 store-exclusive.
  - The cycle after acceptance, `rsp_valid_o` is high and `rsp_id_o` names the accepted processor.
  - For loads, `rsp_rdata_o` holds the memory word as it was before that cycle.
  - `rsp_status_o` is 0 for every operation except a failed store-exclusive.
- R3: A shared load-exclusive reserves that word for the requester. A later shared store-exclusive to the same word by the same processor writes the word, returns status 0 and drops the reservation.
- R4: A shared load-exclusive to a new address replaces that processor's earlier reservation. A store-exclusive to the old address then fails.
- R5: A shared store-exclusive to a word the requester has not reserved returns status 1 and leaves memory unchanged. It still drops the requester's reservation.
- R6: A non-shared load-exclusive sets the requester's pending flag. The next non-shared store-exclusive from that processor succeeds at any address, writes, returns status 0 and clears the flag.
- R7: A non-shared store-exclusive without a pending flag returns status 1 and does not write.
- R8: A successful plain or exclusive store to a shared word cancels the reservations that other processors hold on that word. The writer's own reservation is left alone.
- R9: `clrex_i[n]` clears both the pending flag and the reservation of processor n. If a load-exclusive from the same processor arrives in the same cycle, the clear wins.
- R10: Reset clears all memory words, all flags and all reservations. A store-exclusive issued right after reset fails.
- R11: Two processors that each run load-exclusive / add-one / store-exclusive with retry on the same shared word never lose an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | N_CPU | Request valid, one bit per processor |
| req_op_i | input | 2*N_CPU | Operation code per processor |
| req_addr_i | input | ADDR_W*N_CPU | Byte address per processor (word aligned) |
| req_wdata_i | input | DATA_W*N_CPU | Write data per processor |
| req_shared_i | input | N_CPU | Shared-location attribute per processor |
| clrex_i | input | N_CPU | Clear reservation state per processor |
| grant_o | output | N_CPU | Processor accepted this cycle |
| rsp_valid_o | output | 1 | Response valid |
| rsp_id_o | output | $clog2(N_CPU) | Processor the response belongs to |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_status_o | output | 1 | Store-exclusive status: 1 means failed |

## Verification
Wrong monitor state cannot be seen directly. It shows up one cycle after the next store-exclusive from the affected processor, as a wrong status bit. If it lets a write through that should have been blocked, a later load also returns the wrong word.

A stale reservation can sit unnoticed for many cycles until some processor tries a store-exclusive. The bench therefore pairs each reserve or cancel action with a store-exclusive, followed by a load of the word involved. The two-processor increment race sums up the whole reservation path: every lost update lowers the final count.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LDEX  = 2'b10,
    OP_STEX  = 2'b11
  } op_e;
endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] id_o
);
  // fixed priority, lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    id_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        id_o     = IW'(i);
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/excl_mon_tags.sv
module excl_mon_tags
  import excl_mon_pkg::*;
#(
  parameter int N   = 4,
  parameter int TW  = 30,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [IW-1:0] id_i,
  input  op_e           op_i,
  input  logic [TW-1:0] waddr_i,
  input  logic          shared_i,
  input  logic [N-1:0]  clrex_i,
  output logic          pass_o,
  output logic          we_o,
  output logic [N-1:0]  loc_o,
  output logic [N-1:0]  tag_v_o,
  output logic [N-1:0][TW-1:0] tag_a_o
);
  logic [N-1:0]          loc_q;
  logic [N-1:0]          tag_v_q;
  logic [N-1:0][TW-1:0]  tag_a_q;

  always_comb begin
    if (shared_i) pass_o = tag_v_q[id_i] && (tag_a_q[id_i] == waddr_i);
    else          pass_o = loc_q[id_i];
  end

  assign we_o = acc_i && ((op_i == OP_STORE) || (op_i == OP_STEX && pass_o));

  for (genvar g = 0; g < N; g++) begin : g_cpu
    localparam logic [IW-1:0] ME = IW'(g);
    logic mine;
    assign mine = acc_i && (id_i == ME);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        loc_q[g] <= 1'b0;
      end else if (clrex_i[g]) begin
        loc_q[g] <= 1'b0;
      end else if (mine && !shared_i && op_i == OP_LDEX) begin
        loc_q[g] <= 1'b1;
      end else if (mine && !shared_i && op_i == OP_STEX) begin
        loc_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_v_q[g] <= 1'b0;
        tag_a_q[g] <= '0;
      end else if (clrex_i[g]) begin
        tag_v_q[g] <= 1'b0;
      end else if (mine && shared_i && op_i == OP_LDEX) begin
        tag_v_q[g] <= 1'b1;
        tag_a_q[g] <= waddr_i;
      end else if (mine && shared_i && op_i == OP_STEX) begin
        tag_v_q[g] <= 1'b0;
      end else if (we_o && shared_i && !mine && tag_a_q[g] == waddr_i) begin
        // another processor wrote our reserved word
        tag_v_q[g] <= 1'b0;
      end
    end
  end

  assign loc_o   = loc_q;
  assign tag_v_o = tag_v_q;
  assign tag_a_o = tag_a_q;
endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int XW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [XW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [WORDS-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (re_i) rdata_o <= mem_q[idx_i];
      if (we_i) mem_q[idx_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int N_CPU     = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 16,
  localparam int IW       = $clog2(N_CPU),
  localparam int TW       = ADDR_W - 2,
  localparam int XW       = $clog2(MEM_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CPU-1:0]         req_valid_i,
  input  logic [2*N_CPU-1:0]       req_op_i,
  input  logic [ADDR_W*N_CPU-1:0]  req_addr_i,
  input  logic [DATA_W*N_CPU-1:0]  req_wdata_i,
  input  logic [N_CPU-1:0]         req_shared_i,
  input  logic [N_CPU-1:0]         clrex_i,
  output logic [N_CPU-1:0]         grant_o,
  output logic                     rsp_valid_o,
  output logic [IW-1:0]            rsp_id_o,
  output logic [DATA_W-1:0]        rsp_rdata_o,
  output logic                     rsp_status_o
);
  logic [IW-1:0]     sel_id;
  logic              acc;
  op_e               sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_shared;
  logic              pass, mem_we;
  logic [N_CPU-1:0]  loc_q, tag_v_q;
  logic [N_CPU-1:0][TW-1:0] tag_a_q;

  excl_mon_arb #(.N(N_CPU)) u_arb (
    .req_i (req_valid_i),
    .gnt_o (grant_o),
    .id_o  (sel_id)
  );

  assign acc        = |grant_o;
  assign sel_op     = op_e'(req_op_i[sel_id*2 +: 2]);
  assign sel_addr   = req_addr_i[sel_id*ADDR_W +: ADDR_W];
  assign sel_wdata  = req_wdata_i[sel_id*DATA_W +: DATA_W];
  assign sel_shared = req_shared_i[sel_id];

  excl_mon_tags #(.N(N_CPU), .TW(TW)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .id_i     (sel_id),
    .op_i     (sel_op),
    .waddr_i  (sel_addr[ADDR_W-1:2]),
    .shared_i (sel_shared),
    .clrex_i  (clrex_i),
    .pass_o   (pass),
    .we_o     (mem_we),
    .loc_o    (loc_q),
    .tag_v_o  (tag_v_q),
    .tag_a_o  (tag_a_q)
  );

  excl_mon_mem #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (acc),
    .we_i    (mem_we),
    .idx_i   (sel_addr[2 +: XW]),
    .wdata_i (sel_wdata),
    .rdata_o (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_id_o     <= '0;
      rsp_status_o <= 1'b0;
    end else begin
      rsp_valid_o  <= acc;
      if (acc) begin
        rsp_id_o     <= sel_id;
        rsp_status_o <= (sel_op == OP_STEX) && !pass;
      end
    end
  end
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
  import excl_mon_pkg::*;
#(
  parameter int N_CPU   = 4,
  localparam int IW     = $clog2(N_CPU)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CPU-1:0] req_valid_i,
  input logic [N_CPU-1:0] clrex_i,
  input logic [N_CPU-1:0] grant_o,
  input logic             rsp_valid_o,
  input logic [IW-1:0]    rsp_id_o,
  input logic             rsp_status_o,
  input logic [IW-1:0]    sel_id,
  input op_e              sel_op,
  input logic             sel_shared,
  input logic             mem_we,
  input logic [N_CPU-1:0] loc_q,
  input logic [N_CPU-1:0] tag_v_q
);
  p_grant_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  for (genvar g = 0; g < N_CPU; g++) begin : g_chk
    localparam logic [N_CPU-1:0] LOWER = N_CPU'((1 << g) - 1);

    p_grant_lowest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[g] |-> (req_valid_i[g] && !(|(req_valid_i & LOWER))));

    p_clrex_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clrex_i[g] |=> (!loc_q[g] && !tag_v_q[g]));
  end

  p_rsp_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |=> (rsp_valid_o && rsp_id_o == $past(sel_id)));

  p_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|grant_o) |=> !rsp_valid_o);

  p_ldex_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && sel_op == OP_LDEX && sel_shared && !clrex_i[sel_id])
      |=> tag_v_q[$past(sel_id)]);

  p_fail_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o) |-> $past(!mem_we));
endmodule

bind excl_monitor excl_mon_chk #(.N_CPU(N_CPU)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .clrex_i      (clrex_i),
  .grant_o      (grant_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_id_o     (rsp_id_o),
  .rsp_status_o (rsp_status_o),
  .sel_id       (sel_id),
  .sel_op       (sel_op),
  .sel_shared   (sel_shared),
  .mem_we       (mem_we),
  .loc_q        (loc_q),
  .tag_v_q      (tag_v_q)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RACE_N = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          v_a  [N];
  logic [1:0]    op_a [N];
  logic [AW-1:0] ad_a [N];
  logic [DW-1:0] wd_a [N];
  logic          sh_a [N];
  logic          cx_a [N];

  logic [N-1:0]    req_valid, req_shared, clrex;
  logic [2*N-1:0]  req_op;
  logic [AW*N-1:0] req_addr;
  logic [DW*N-1:0] req_wdata;
  logic [N-1:0]    grant;
  logic            rsp_valid, rsp_status;
  logic [1:0]      rsp_id;
  logic [DW-1:0]   rsp_rdata;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = v_a[i];
      req_op[i*2 +: 2]      = op_a[i];
      req_addr[i*AW +: AW]  = ad_a[i];
      req_wdata[i*DW +: DW] = wd_a[i];
      req_shared[i]         = sh_a[i];
      clrex[i]              = cx_a[i];
    end
  end

  excl_monitor u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_shared_i(req_shared), .clrex_i(clrex),
    .grant_o(grant), .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id),
    .rsp_rdata_o(rsp_rdata), .rsp_status_o(rsp_status)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LX = 2'b10, SX = 2'b11;

  task automatic do_req(input int id, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] d, input logic sh,
                        output logic [31:0] rd, output logic st, output logic ok);
    logic g;
    @(negedge clk);
    v_a[id] = 1'b1; op_a[id] = op; ad_a[id] = a; wd_a[id] = d; sh_a[id] = sh;
    forever begin
      #1;
      g = grant[id];
      @(negedge clk);
      if (g) begin
        rd = rsp_rdata; st = rsp_status;
        ok = rsp_valid && (rsp_id == 2'(id));
        v_a[id] = 1'b0;
        return;
      end
    end
  endtask

  typedef struct packed {
    logic [1:0]  cpu;
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        sh;
    logic        exp_st;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd0, ST, 32'h10, 32'hA0A0_0001, 1'b1, 1'b0, 1'b0, 32'h0,          4'd2},  // R2 plain store
    '{2'd0, LD, 32'h10, 32'h0,         1'b1, 1'b0, 1'b1, 32'hA0A0_0001, 4'd2},  // R2 load
    '{2'd1, SX, 32'h10, 32'hB0B0_0002, 1'b1, 1'b1, 1'b0, 32'h0,          4'd5},  // R5 no tag
    '{2'd1, LD, 32'h10, 32'h0,         1'b1, 1'b0, 1'b1, 32'hA0A0_0001, 4'd5},  // R5 no write
    '{2'd1, LX, 32'h10, 32'h0,         1'b1, 1'b0, 1'b1, 32'hA0A0_0001, 4'd3},  // R3 reserve
    '{2'd1, SX, 32'h10, 32'hB0B0_0002, 1'b1, 1'b0, 1'b0, 32'h0,          4'd3},  // R3 pass
    '{2'd1, LD, 32'h10, 32'h0,         1'b1, 1'b0, 1'b1, 32'hB0B0_0002, 4'd3},  // R3 written
    '{2'd1, SX, 32'h10, 32'hC0C0_0003, 1'b1, 1'b1, 1'b0, 32'h0,          4'd3},  // R3 tag dropped
    '{2'd2, LX, 32'h14, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd4},  // R4
    '{2'd2, LX, 32'h18, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd4},  // R4 replace
    '{2'd2, SX, 32'h14, 32'hD0D0_0004, 1'b1, 1'b1, 1'b0, 32'h0,          4'd4},  // R4 old addr fails
    '{2'd2, LD, 32'h14, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd4},  // R4 no write
    '{2'd2, LX, 32'h18, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd8},  // R8
    '{2'd3, LX, 32'h18, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd8},  // R8
    '{2'd3, ST, 32'h18, 32'hE0E0_0005, 1'b1, 1'b0, 1'b0, 32'h0,          4'd8},  // R8 plain store by 3
    '{2'd2, SX, 32'h18, 32'hF0F0_0006, 1'b1, 1'b1, 1'b0, 32'h0,          4'd8},  // R8 cpu2 lost tag
    '{2'd3, SX, 32'h18, 32'h1234_0007, 1'b1, 1'b0, 1'b0, 32'h0,          4'd8},  // R8 own tag kept
    '{2'd3, LD, 32'h18, 32'h0,         1'b1, 1'b0, 1'b1, 32'h1234_0007, 4'd8},  // R8
    '{2'd0, SX, 32'h20, 32'h5555_0008, 1'b0, 1'b1, 1'b0, 32'h0,          4'd7},  // R7 no flag
    '{2'd0, LD, 32'h20, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0,          4'd7},  // R7 no write
    '{2'd0, LX, 32'h20, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0,          4'd6},  // R6 flag
    '{2'd0, SX, 32'h24, 32'h6666_0009, 1'b0, 1'b0, 1'b0, 32'h0,          4'd6},  // R6 any addr
    '{2'd0, LD, 32'h24, 32'h0,         1'b0, 1'b0, 1'b1, 32'h6666_0009, 4'd6},  // R6 written
    '{2'd0, SX, 32'h24, 32'h7777_000A, 1'b0, 1'b1, 1'b0, 32'h0,          4'd6},  // R6 flag cleared
    '{2'd1, LX, 32'h28, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd5},  // R5
    '{2'd1, SX, 32'h2C, 32'h8888_000B, 1'b1, 1'b1, 1'b0, 32'h0,          4'd5},  // R5 mismatch
    '{2'd1, SX, 32'h28, 32'h8888_000B, 1'b1, 1'b1, 1'b0, 32'h0,          4'd5},  // R5 tag dropped
    '{2'd1, LD, 32'h28, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0,          4'd5},  // R5
    '{2'd0, LX, 32'h20, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0,          4'd6},  // R6 flag only
    '{2'd0, SX, 32'h20, 32'h9999_000C, 1'b1, 1'b1, 1'b0, 32'h0,          4'd6}   // R6 shared ignores flag
  };

  task automatic race_thread(input int id, output int retries);
    logic [31:0] rd; logic st, ok;
    retries = 0;
    for (int k = 0; k < RACE_N; k++) begin
      st = 1'b1;
      while (st) begin
        do_req(id, LX, 32'h3C, 32'h0, 1'b1, rd, st, ok);
        repeat ((k + id) % 3) @(negedge clk);
        do_req(id, SX, 32'h3C, rd + 32'd1, 1'b1, rd, st, ok);
        if (st) retries++;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic st, ok;
    time t1, t2;
    int r0, r1;
    for (int i = 0; i < N; i++) begin
      v_a[i] = 0; op_a[i] = 0; ad_a[i] = 0; wd_a[i] = 0; sh_a[i] = 0; cx_a[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 0);
    chk(grant == '0, "R10 reset grant", 32'(grant), 0);

    // R10: store-exclusive right after reset fails
    do_req(3, SX, 32'h0, 32'hFFFF, 1'b1, rd, st, ok);
    chk(ok && st == 1'b1, "R10 stex after reset", 32'(st), 1);
    do_req(3, SX, 32'h0, 32'hFFFF, 1'b0, rd, st, ok);
    chk(ok && st == 1'b1, "R10 ns stex after reset", 32'(st), 1);

    for (int i = 0; i < NV; i++) begin
      do_req(int'(VEC[i].cpu), VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].sh, rd, st, ok);
      chk(ok, $sformatf("R2 vec%0d rsp", i), 32'(ok), 1);
      chk(st == VEC[i].exp_st, $sformatf("R%0d vec%0d status", VEC[i].rq, i), 32'(st), 32'(VEC[i].exp_st));
      if (VEC[i].chk_rd)
        chk(rd == VEC[i].exp_rd, $sformatf("R%0d vec%0d rdata", VEC[i].rq, i), rd, VEC[i].exp_rd);
    end

    // R1: simultaneous requests, lower id first
    fork
      begin do_req(2, LD, 32'h18, 0, 1'b1, rd, st, ok); t2 = $time; end
      begin logic [31:0] r; logic s, o; do_req(1, LD, 32'h10, 0, 1'b1, r, s, o); t1 = $time;
        chk(o && r == 32'hB0B0_0002, "R1 cpu1 data", r, 32'hB0B0_0002); end
    join
    chk(t1 < t2, "R1 cpu1 before cpu2", 32'(t1), 32'(t2));
    chk(rd == 32'h1234_0007, "R1 cpu2 served", rd, 32'h1234_0007);

    // R9: clrex clears flag and tag
    do_req(3, LX, 32'h30, 0, 1'b1, rd, st, ok);
    do_req(3, LX, 32'h34, 0, 1'b0, rd, st, ok);
    @(negedge clk); cx_a[3] = 1'b1; @(negedge clk); cx_a[3] = 1'b0;
    do_req(3, SX, 32'h30, 32'h1, 1'b1, rd, st, ok);
    chk(st == 1'b1, "R9 shared tag cleared", 32'(st), 1);
    do_req(3, SX, 32'h34, 32'h1, 1'b0, rd, st, ok);
    chk(st == 1'b1, "R9 local flag cleared", 32'(st), 1);
    // R9: clear wins over same-cycle load-exclusive
    @(negedge clk);
    cx_a[2] = 1'b1;
    v_a[2] = 1'b1; op_a[2] = LX; ad_a[2] = 32'h30; sh_a[2] = 1'b1;
    @(negedge clk);
    cx_a[2] = 1'b0; v_a[2] = 1'b0;
    do_req(2, SX, 32'h30, 32'h2, 1'b1, rd, st, ok);
    chk(st == 1'b1, "R9 clear beats ldex", 32'(st), 1);
    do_req(2, LD, 32'h30, 0, 1'b1, rd, st, ok);
    chk(rd == 32'h0, "R9 no write", rd, 0);

    // R11: two-processor increment race
    fork
      race_thread(0, r0);
      race_thread(1, r1);
    join
    do_req(2, LD, 32'h3C, 0, 1'b1, rd, st, ok);
    chk(rd == 32'(2 * RACE_N), "R11 no lost update", rd, 32'(2 * RACE_N));
    $display("race retries: cpu0=%0d cpu1=%0d", r0, r1);

    // R10: reset mid-run drops reservation and memory
    do_req(0, LX, 32'h3C, 0, 1'b1, rd, st, ok);
    @(negedge clk); rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1;
    do_req(0, SX, 32'h3C, 32'h9, 1'b1, rd, st, ok);
    chk(st == 1'b1, "R10 reservation reset", 32'(st), 1);
    do_req(0, LD, 32'h3C, 0, 1'b1, rd, st, ok);
    chk(rd == 32'h0, "R10 memory reset", rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule